// File: doc/BRIEF.md
# Audio Sample Word Packer with Buffer Sequencer

This block sits behind an audio decimation stage. It takes 16-bit left and right samples, each pair marked by a valid strobe, packs them into 32-bit words and writes those words to a sample memory through a single-cycle write port. Each transfer begins at a programmed base address and ends after a programmed number of samples. In stereo mode one sample is one left/right pair, and the transfer writes one word per sample. In mono mode only the left channel is kept, and each word holds two successive samples, so N samples take ceil(N/2) words.

Software must hold the block enabled before a start strobe is accepted. A start strobe copies the base address, the sample count and the mode, so the next buffer can be programmed while the current one fills. A stop strobe ends the transfer early. If a mono word is half full at that point, it is flushed. Three event flags are kept: started, stopped and end. Each flag is cleared by a strobe. An interrupt mask, with a set port and a clear port, selects which flags drive the interrupt line.

Top module: `pdm_pack_seq`

## Requirements
- R1: After reset, mem_we is 0, evt_flags is 3'b000, int_mask is 3'b000 and irq is 0. Event bit positions are bit 0 started, bit 1 stopped and bit 2 end.
- R2: A start strobe is accepted only while cfg_enable is 1 and no transfer is running. An accepted start sets evt_flags[0] on the next cycle. A start while disabled, or while a transfer is running, has no effect on flags, addresses or writes.
- R3: In stereo mode (cfg_stereo=1), each accepted sample writes one word with the left sample in bits 15:0 and the right sample in bits 31:16.
- R4: In mono mode (cfg_stereo=0), the right input is ignored. The earlier of two left samples goes in bits 15:0 and the later in bits 31:16. An odd count ends with a word whose bits 31:16 are zero, so N samples give ceil(N/2) writes.
- R5: Word k of a transfer is written at base+4*k. The base address, count and mode are copied at start, and later changes to cfg_base, cfg_count or cfg_stereo do not affect the running transfer.
- R6: When the last sample allowed by the count has been accepted, evt_flags[2] is set and the transfer ends. Samples that arrive later produce no writes.
- R7: A stop strobe during a transfer sets evt_flags[1] and evt_flags[2] and ends the transfer. A half-filled mono word is written with bits 31:16 zero. A sample valid in the same cycle as the stop is ignored.
- R8: A 1 in bit i of evt_clr clears flag i. When an event sets a flag in the same cycle that it is cleared, the set wins.
- R9: int_set_we ORs int_set_bits into int_mask, and int_clr_we removes int_clr_bits from it. irq is 1 exactly when some flag and its mask bit were both set one cycle earlier.
- R10: A start with a count of zero sets the started and end flags together and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Block enable; a start is accepted only while this is 1 |
| cfg_stereo | input | 1 | 1 = stereo, 0 = mono; copied at start |
| cfg_base | input | AW | Byte address of the first word; copied at start |
| cfg_count | input | CW | Number of samples to capture; copied at start |
| start_stb | input | 1 | Start strobe |
| stop_stb | input | 1 | Stop strobe |
| smp_valid | input | 1 | Sample pair valid |
| smp_left | input | 16 | Left sample |
| smp_right | input | 16 | Right sample |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| evt_clr | input | 3 | Per-flag clear strobes |
| evt_flags | output | 3 | Event flags {end, stopped, started} |
| int_set_we | input | 1 | Mask set strobe |
| int_set_bits | input | 3 | Mask bits to set |
| int_clr_we | input | 1 | Mask clear strobe |
| int_clr_bits | input | 3 | Mask bits to clear |
| int_mask | output | 3 | Current interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
A sample or stop strobe captured at one clock edge produces its memory write and its event flags at that same edge. They are therefore visible one cycle after the stimulus, and irq follows one cycle after the flags. The bench drives every input on the falling edge and reads outputs on the next falling edge, or on the second one for irq. A driver pushes every expected word, with its address, into a queue. A monitor on the falling edge pops and compares each write as it appears, and it reports any write that arrives while the queue is empty. This covers the requirements that samples arriving after the end, after a stop or while disabled are ignored.

// File: rtl/pks_pkg.sv
package pks_pkg;
  localparam int NUM_EV = 3;
  localparam int EV_START = 0;
  localparam int EV_STOP = 1;
  localparam int EV_END = 2;
  localparam int SMP_W = 16;
  localparam int WORD_W = 2 * SMP_W;

  typedef logic [NUM_EV-1:0] ev_vec_t;
endpackage

// File: rtl/pks_seq.sv
module pks_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          stereo_in,
  input  logic [AW-1:0] base_in,
  input  logic [CW-1:0] count_in,
  input  logic          start,
  input  logic          stop,
  input  logic          smp_valid,
  input  logic          wr_now,
  output logic          run,
  output logic          stereo_q,
  output logic          acc,
  output logic          last,
  output logic          halt,
  output logic          go,
  output pks_pkg::ev_vec_t ev,
  output logic [AW-1:0] mem_addr
);
  import pks_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(4);
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic          run_q;
  logic [CW-1:0] rem_q;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] maddr_q;
  logic          zero_cnt;

  assign go       = start & enable & ~run_q;
  assign zero_cnt = (count_in == '0);
  assign acc      = run_q & smp_valid & ~stop;
  assign halt     = run_q & stop;
  assign last     = acc & (rem_q == ONE);

  always_comb begin
    ev           = '0;
    ev[EV_START] = go;
    ev[EV_STOP]  = halt;
    ev[EV_END]   = last | halt | (go & zero_cnt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      rem_q    <= '0;
      addr_q   <= '0;
      maddr_q  <= '0;
      stereo_q <= 1'b0;
    end else begin
      if (go) begin
        run_q    <= ~zero_cnt;
        rem_q    <= count_in;
        addr_q   <= base_in;
        stereo_q <= stereo_in;
      end else begin
        if (last || halt) run_q <= 1'b0;
        if (acc) rem_q <= rem_q - ONE;
      end
      if (wr_now) begin
        maddr_q <= addr_q;
        addr_q  <= addr_q + STEP;
      end
    end
  end

  assign run      = run_q;
  assign mem_addr = maddr_q;

  assert_run_has_samples_R6: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (rem_q != '0));
  assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(run_q) |-> $past(enable));
endmodule

// File: rtl/pks_pack.sv
module pks_pack #(
  parameter int SW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stereo,
  input  logic          acc,
  input  logic          last,
  input  logic          halt,
  input  logic [SW-1:0] left,
  input  logic [SW-1:0] right,
  output logic          wr_now,
  output logic          half,
  output logic          mem_we,
  output logic [2*SW-1:0] mem_wdata
);
  localparam int WW = 2 * SW;

  logic          half_q;
  logic [SW-1:0] hold_q;
  logic [WW-1:0] word;
  logic          half_d;

  always_comb begin
    wr_now = 1'b0;
    word   = '0;
    half_d = half_q;
    if (stereo) begin
      if (acc) begin
        wr_now = 1'b1;
        word   = {right, left};
      end
    end else if (acc) begin
      if (half_q) begin
        wr_now = 1'b1;
        word   = {left, hold_q};
        half_d = 1'b0;
      end else if (last) begin
        wr_now = 1'b1;
        word   = {{SW{1'b0}}, left};
      end else begin
        half_d = 1'b1;
      end
    end else if (halt && half_q) begin
      wr_now = 1'b1;
      word   = {{SW{1'b0}}, hold_q};
      half_d = 1'b0;
    end
    if (halt) half_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q    <= 1'b0;
      hold_q    <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      half_q <= half_d;
      if (acc && !stereo && !half_q) hold_q <= left;
      mem_we <= wr_now;
      if (wr_now) mem_wdata <= word;
    end
  end

  assign half = half_q;

  assert_stereo_no_half_R3: assert property (@(posedge clk) disable iff (rst)
    (stereo && !$past(half_q)) |-> !half_q);
  assert_mono_pair_R4: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !stereo && $past(half_q) && !$past(halt)) |-> !half_q);
endmodule

// File: rtl/pks_evt.sv
module pks_evt #(
  parameter int NE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] ev,
  input  logic [NE-1:0] clr,
  input  logic          set_we,
  input  logic [NE-1:0] set_bits,
  input  logic          clr_we,
  input  logic [NE-1:0] clr_bits,
  output logic [NE-1:0] flags,
  output logic [NE-1:0] mask,
  output logic          irq
);
  logic [NE-1:0] flag_q;
  logic [NE-1:0] mask_q;
  logic          irq_q;

  for (genvar i = 0; i < NE; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        if (ev[i]) flag_q[i] <= 1'b1;
        else if (clr[i]) flag_q[i] <= 1'b0;
        if (clr_we && clr_bits[i]) mask_q[i] <= 1'b0;
        else if (set_we && set_bits[i]) mask_q[i] <= 1'b1;
      end
    end

    assert_flag_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      ev[i] |=> flag_q[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |(flag_q & mask_q);
  end

  assign flags = flag_q;
  assign mask  = mask_q;
  assign irq   = irq_q;
endmodule

// File: rtl/pdm_pack_seq.sv
module pdm_pack_seq #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_enable,
  input  logic          cfg_stereo,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_count,
  input  logic          start_stb,
  input  logic          stop_stb,
  input  logic          smp_valid,
  input  logic [15:0]   smp_left,
  input  logic [15:0]   smp_right,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [31:0]   mem_wdata,
  input  logic [2:0]    evt_clr,
  output logic [2:0]    evt_flags,
  input  logic          int_set_we,
  input  logic [2:0]    int_set_bits,
  input  logic          int_clr_we,
  input  logic [2:0]    int_clr_bits,
  output logic [2:0]    int_mask,
  output logic          irq
);
  import pks_pkg::*;

  logic    run, stereo_q, acc, last, halt, go, wr_now, half;
  ev_vec_t ev;

  pks_seq #(.AW(AW), .CW(CW)) i_seq (
    .clk(clk), .rst(rst), .enable(cfg_enable), .stereo_in(cfg_stereo),
    .base_in(cfg_base), .count_in(cfg_count), .start(start_stb),
    .stop(stop_stb), .smp_valid(smp_valid), .wr_now(wr_now), .run(run),
    .stereo_q(stereo_q), .acc(acc), .last(last), .halt(halt), .go(go),
    .ev(ev), .mem_addr(mem_addr)
  );

  pks_pack #(.SW(SMP_W)) i_pack (
    .clk(clk), .rst(rst), .stereo(stereo_q), .acc(acc), .last(last),
    .halt(halt), .left(smp_left), .right(smp_right), .wr_now(wr_now),
    .half(half), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  pks_evt #(.NE(NUM_EV)) i_evt (
    .clk(clk), .rst(rst), .ev(ev), .clr(evt_clr), .set_we(int_set_we),
    .set_bits(int_set_bits), .clr_we(int_clr_we), .clr_bits(int_clr_bits),
    .flags(evt_flags), .mask(int_mask), .irq(irq)
  );

  logic          chk_pv;
  logic [AW-1:0] chk_pa;
  always_ff @(posedge clk) begin
    if (rst || go) begin
      chk_pv <= 1'b0;
      chk_pa <= '0;
    end else if (mem_we) begin
      chk_pv <= 1'b1;
      chk_pa <= mem_addr;
    end
  end

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && chk_pv) |-> (mem_addr == chk_pa + AW'(4)));
  assert_write_while_running_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(run));
  assert_idle_no_half_R7: assert property (@(posedge clk) disable iff (rst)
    !run |-> !half);
  assert_irq_needs_flag_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|evt_flags));
endmodule

// File: tb/test_pdm_pack_seq.sv
module test_pdm_pack_seq;
  localparam int AW = 16;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_enable = 1'b0, cfg_stereo = 1'b1;
  logic [AW-1:0] cfg_base = '0;
  logic [CW-1:0] cfg_count = '0;
  logic start_stb = 1'b0, stop_stb = 1'b0, smp_valid = 1'b0;
  logic [15:0] smp_left = '0, smp_right = '0;
  logic mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [2:0] evt_clr = '0, evt_flags;
  logic int_set_we = 1'b0, int_clr_we = 1'b0;
  logic [2:0] int_set_bits = '0, int_clr_bits = '0, int_mask;
  logic irq;

  int tests = 0;
  int fails = 0;
  logic [47:0] exp_q[$];

  always #4 clk = ~clk;

  pdm_pack_seq #(.AW(AW), .CW(CW)) i_pdm_pack_seq (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_stereo(cfg_stereo),
    .cfg_base(cfg_base), .cfg_count(cfg_count), .start_stb(start_stb),
    .stop_stb(stop_stb), .smp_valid(smp_valid), .smp_left(smp_left),
    .smp_right(smp_right), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .evt_clr(evt_clr), .evt_flags(evt_flags),
    .int_set_we(int_set_we), .int_set_bits(int_set_bits),
    .int_clr_we(int_clr_we), .int_clr_bits(int_clr_bits),
    .int_mask(int_mask), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act,
                     input logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every write
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected write", {mem_addr, mem_wdata}, 48'h0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        chk({mem_addr, mem_wdata} == e, "R3 R4 R5 write", {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_start(input logic st, input logic [AW-1:0] b, input logic [CW-1:0] n);
    cfg_stereo = st; cfg_base = b; cfg_count = n; start_stb = 1'b1;
    tick();
    start_stb = 1'b0;
  endtask

  task automatic send(input logic [15:0] l, input logic [15:0] r);
    smp_valid = 1'b1; smp_left = l; smp_right = r;
    tick();
    smp_valid = 1'b0;
  endtask

  task automatic expect_wr(input logic [AW-1:0] a, input logic [31:0] d);
    exp_q.push_back({a, d});
  endtask

  task automatic clear_all();
    evt_clr = 3'b111;
    tick();
    evt_clr = 3'b000;
  endtask

  task automatic drained(input string tag);
    chk(exp_q.size() == 0, tag, 48'(exp_q.size()), 48'h0);
  endtask

  initial begin
    repeat (30000) @(posedge clk);
    chk(1'b0, "watchdog", 48'h0, 48'h1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk(mem_we == 1'b0, "R1 mem_we", 48'(mem_we), 48'h0);
    chk(evt_flags == 3'b000, "R1 flags", 48'(evt_flags), 48'h0);
    chk(int_mask == 3'b000, "R1 mask", 48'(int_mask), 48'h0);
    chk(irq == 1'b0, "R1 irq", 48'(irq), 48'h0);

    // R2 start while disabled is ignored
    do_start(1'b1, 16'h0040, 16'd2);
    chk(evt_flags == 3'b000, "R2 disabled start", 48'(evt_flags), 48'h0);
    send(16'h1111, 16'h2222);
    tick();
    drained("R2 no write while disabled");

    // R9 mask set
    int_set_we = 1'b1; int_set_bits = 3'b111;
    tick();
    int_set_we = 1'b0;
    chk(int_mask == 3'b111, "R9 mask set", 48'(int_mask), 48'h7);

    // stereo transfer, R3 R5 R6
    cfg_enable = 1'b1;
    do_start(1'b1, 16'h0100, 16'd3);
    chk(evt_flags == 3'b001, "R2 started flag", 48'(evt_flags), 48'h1);
    cfg_base = 16'h0800; cfg_count = 16'd9; cfg_stereo = 1'b0; // R5 latched
    tick();
    chk(irq == 1'b1, "R9 irq follows flag", 48'(irq), 48'h1);
    expect_wr(16'h0100, 32'hB001_A001); send(16'hA001, 16'hB001);
    expect_wr(16'h0104, 32'hB002_A002); send(16'hA002, 16'hB002);
    chk(evt_flags[2] == 1'b0, "R6 no early end", 48'(evt_flags), 48'h1);
    expect_wr(16'h0108, 32'hB003_A003); send(16'hA003, 16'hB003);
    chk(evt_flags == 3'b101, "R6 end flag", 48'(evt_flags), 48'h5);
    send(16'hEEEE, 16'hEEEE);
    tick();
    drained("R6 stereo words");
    clear_all();
    chk(evt_flags == 3'b000, "R8 clear", 48'(evt_flags), 48'h0);
    tick();
    chk(irq == 1'b0, "R9 irq drops", 48'(irq), 48'h0);

    // mono odd count, R4; clear with start same cycle, R8
    evt_clr = 3'b001;
    do_start(1'b0, 16'h0200, 16'd5);
    evt_clr = 3'b000;
    chk(evt_flags == 3'b001, "R8 set wins", 48'(evt_flags), 48'h1);
    send(16'h000A, 16'h9999);
    do_start(1'b1, 16'h0F00, 16'd1); // R2 start while running ignored
    expect_wr(16'h0200, 32'h000B_000A); send(16'h000B, 16'h9999);
    send(16'h000C, 16'h9999);
    expect_wr(16'h0204, 32'h000D_000C); send(16'h000D, 16'h9999);
    expect_wr(16'h0208, 32'h0000_000E); send(16'h000E, 16'h9999);
    chk(evt_flags == 3'b101, "R4 end after odd count", 48'(evt_flags), 48'h5);
    send(16'h000F, 16'h9999);
    tick();
    drained("R4 mono words");
    clear_all();

    // mono stop mid-word with sample same cycle, R7
    do_start(1'b0, 16'h0300, 16'd10);
    send(16'h0021, 16'h0);
    expect_wr(16'h0300, 32'h0022_0021); send(16'h0022, 16'h0);
    send(16'h0023, 16'h0);
    expect_wr(16'h0304, 32'h0000_0023);
    stop_stb = 1'b1; smp_valid = 1'b1; smp_left = 16'hDEAD;
    tick();
    stop_stb = 1'b0; smp_valid = 1'b0;
    chk(evt_flags == 3'b111, "R7 stop flags", 48'(evt_flags), 48'h7);
    send(16'h0024, 16'h0);
    tick();
    drained("R7 flush word");
    clear_all();

    // stereo stop with nothing pending, R7
    do_start(1'b1, 16'h0400, 16'd8);
    expect_wr(16'h0400, 32'h5678_1234); send(16'h1234, 16'h5678);
    stop_stb = 1'b1;
    tick();
    stop_stb = 1'b0;
    chk(evt_flags == 3'b111, "R7 stereo stop flags", 48'(evt_flags), 48'h7);
    tick();
    drained("R7 no flush in stereo");
    clear_all();

    // zero count, R10
    do_start(1'b1, 16'h0500, 16'd0);
    chk(evt_flags == 3'b101, "R10 zero count flags", 48'(evt_flags), 48'h5);
    send(16'h7777, 16'h7777);
    tick();
    drained("R10 no writes");

    // mask clear leaves only stopped enabled, R9
    int_clr_we = 1'b1; int_clr_bits = 3'b101;
    tick();
    int_clr_we = 1'b0;
    chk(int_mask == 3'b010, "R9 mask clear", 48'(int_mask), 48'h2);
    tick();
    chk(irq == 1'b0, "R9 masked irq", 48'(irq), 48'h0);

    repeat (2) tick();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule